// File: doc/BRIEF.md
# Receive Clock and Carrier-Sense Sequencer

This block sits between a 10 Mb/s Manchester decoder and a LAN controller. It produces the receive clock, the receive data and the carrier-sense indication that the controller sees. Every output is a register on a single master clock. The transmit clock phase and the recovered clock phase arrive as levels that are synchronous to that master clock.

When reception begins, the decoder's clock-recovery loop needs a fixed interval to lock. During that interval the block either copies the local transmit clock onto the receive clock or holds the receive clock low. Which of the two it does is chosen by a mode input. Once the interval has passed, the block hands the receive clock over to the recovered phase. The handover happens only in a master cycle where both the old and the new source are low, so no short pulse reaches the controller.

Receive data changes only on rising edges of the receive clock, and it reads zero until the recovered clock is in use. Carrier sense follows receive activity or collision. After every local transmission, carrier sense is forced off for a fixed blanking window.

Top module: `rxcs_seq`

## Requirements
- R1: While `rst_n` is low, `rxc_o`, `rxd_o` and `crs_o` are all 0.
- R2: With `mode_b` = 0, `rxc_o` equals the `tx_phase` value of the previous master cycle during the first 30 master cycles in which `rx_act` is sampled high, and at all times while idle.
- R3: With `mode_b` = 1, `rxc_o` is 0 during the first 30 master cycles in which `rx_act` is sampled high, and at all times while idle.
- R4: The receive clock changes to the recovered source only after the 30-cycle lock interval has elapsed. Any change of source happens only in a cycle where the outgoing and incoming source levels are both 0. From the 34th cycle of reception onward, `rxc_o` equals the `rec_phase` value of the previous cycle.
- R5: Outside the blanking window, `crs_o` equals (`rx_act` OR `col_act`) sampled one master cycle earlier.
- R6: `rxd_o` is 0 whenever the receive clock is not on the recovered source, and in particular throughout the 30-cycle lock interval.
- R7: While on the recovered source, `rxd_o` changes only in a cycle where `rxc_o` rises from 0 to 1. It then takes the `rec_bit` value sampled at that edge.
- R8: When `rx_act` drops, `rxc_o` returns to its idle source within 4 master cycles and `rxd_o` returns to 0.
- R9: After the first master cycle in which `tx_act` is sampled low following a high, `crs_o` is 0 for 88 master cycles regardless of `rx_act` and `col_act`. The lock timer keeps running during this window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock (20 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_b | input | 1 | 0: copy transmit clock during lock; 1: hold receive clock low during lock |
| rx_act | input | 1 | Receive activity on the selected port |
| col_act | input | 1 | Collision indication |
| rec_phase | input | 1 | Recovered clock phase from the decoder |
| rec_bit | input | 1 | Recovered data bit from the decoder |
| tx_phase | input | 1 | Local transmit clock phase |
| tx_act | input | 1 | Local transmission in progress |
| rxc_o | output | 1 | Receive clock to the controller |
| rxd_o | output | 1 | Receive data to the controller |
| crs_o | output | 1 | Carrier sense to the controller (active high) |

## Verification
Two functions can act in the same cycle: the lock-interval timer and the carrier-sense blanking window. The bench provokes this by starting reception at a range of offsets inside and around the 88-cycle window after a transmission. It then checks two things on every cycle. First, carrier sense stays off exactly until the window expires. Second, the receive clock still hands over to the recovered phase on schedule, counted from the start of reception.

Both clock phases run with several relative offsets in both modes. This moves the both-low handover cycle around, so the no-runt rule and the receive-data launch rule are judged against different alignments.

// File: rtl/rxcs_pkg.sv
package rxcs_pkg;

  typedef enum logic {
    SRC_IDLE      = 1'b0,
    SRC_RECOVERED = 1'b1
  } rxc_src_e;

  // master cycles needed to cover a span in ns, rounded up
  function automatic int unsigned span_cycles(input int unsigned span_ns,
                                              input int unsigned clk_mhz);
    return (span_ns * clk_mhz + 999) / 1000;
  endfunction

  // counter width able to hold values 0..limit
  function automatic int unsigned count_bits(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/rxcs_lock_timer.sv
module rxcs_lock_timer #(
  parameter int unsigned LOCK_CYC = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_act,
  output logic locked
);
  import rxcs_pkg::*;
  localparam int unsigned W = count_bits(LOCK_CYC);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!rx_act) begin
      cnt_q <= '0;
    end else if (cnt_q != W'(LOCK_CYC)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign locked = (cnt_q == W'(LOCK_CYC));
endmodule

// File: rtl/rxcs_blank_timer.sv
module rxcs_blank_timer #(
  parameter int unsigned BLANK_CYC = 88
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_act,
  output logic blanking,
  output logic quiet_next
);
  import rxcs_pkg::*;
  localparam int unsigned W = count_bits(BLANK_CYC);

  logic         tx_q;
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         tx_end;

  assign tx_end = tx_q & ~tx_act;

  always_comb begin
    if (tx_end)            cnt_d = W'(BLANK_CYC);
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    else                   cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      tx_q  <= tx_act;
      cnt_q <= cnt_d;
    end
  end

  assign blanking   = (cnt_q != '0);
  assign quiet_next = (cnt_d == '0);
endmodule

// File: rtl/rxcs_clk_steer.sv
module rxcs_clk_steer (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_b,
  input  logic tx_phase,
  input  logic rec_phase,
  input  logic rec_bit,
  input  logic want_rec,
  output logic idle_src,
  output logic sel_rec,
  output logic rxc_o,
  output logic rxd_o
);
  import rxcs_pkg::*;

  rxc_src_e src_q, src_d;
  logic     both_low;
  logic     rxc_d;
  logic     rise_d;

  assign idle_src = mode_b ? 1'b0 : tx_phase;
  assign both_low = ~idle_src & ~rec_phase;

  always_comb begin
    src_d = src_q;
    if (both_low) src_d = want_rec ? SRC_RECOVERED : SRC_IDLE;
  end

  assign rxc_d  = (src_d == SRC_RECOVERED) ? rec_phase : idle_src;
  assign rise_d = rxc_d & ~rxc_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= SRC_IDLE;
      rxc_o <= 1'b0;
      rxd_o <= 1'b0;
    end else begin
      src_q <= src_d;
      rxc_o <= rxc_d;
      if (src_d != SRC_RECOVERED) rxd_o <= 1'b0;
      else if (rise_d)            rxd_o <= rec_bit;
    end
  end

  assign sel_rec = (src_q == SRC_RECOVERED);
endmodule

// File: rtl/rxcs_seq.sv
module rxcs_seq #(
  parameter int unsigned CLK_MHZ  = 20,
  parameter int unsigned LOCK_NS  = 1500,
  parameter int unsigned BLANK_NS = 4400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_b,
  input  logic rx_act,
  input  logic col_act,
  input  logic rec_phase,
  input  logic rec_bit,
  input  logic tx_phase,
  input  logic tx_act,
  output logic rxc_o,
  output logic rxd_o,
  output logic crs_o
);
  import rxcs_pkg::*;
  localparam int unsigned LOCK_CYC  = span_cycles(LOCK_NS, CLK_MHZ);
  localparam int unsigned BLANK_CYC = span_cycles(BLANK_NS, CLK_MHZ);

  logic locked;
  logic blanking;
  logic quiet_next;
  logic idle_src;
  logic sel_rec;
  logic want_rec;

  rxcs_lock_timer #(.LOCK_CYC(LOCK_CYC)) u_lock (
    .clk(clk), .rst_n(rst_n), .rx_act(rx_act), .locked(locked)
  );

  rxcs_blank_timer #(.BLANK_CYC(BLANK_CYC)) u_blank (
    .clk(clk), .rst_n(rst_n), .tx_act(tx_act),
    .blanking(blanking), .quiet_next(quiet_next)
  );

  assign want_rec = rx_act & locked;

  rxcs_clk_steer u_steer (
    .clk(clk), .rst_n(rst_n), .mode_b(mode_b), .tx_phase(tx_phase),
    .rec_phase(rec_phase), .rec_bit(rec_bit), .want_rec(want_rec),
    .idle_src(idle_src), .sel_rec(sel_rec), .rxc_o(rxc_o), .rxd_o(rxd_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crs_o <= 1'b0;
    else        crs_o <= (rx_act | col_act) & quiet_next;
  end
endmodule

// File: rtl/rxcs_seq_chk.sv
module rxcs_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic mode_b,
  input logic rec_phase,
  input logic idle_src,
  input logic sel_rec,
  input logic locked,
  input logic blanking,
  input logic rxc_o,
  input logic rxd_o,
  input logic crs_o
);
  assert_hold_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_b) && !sel_rec) |-> !rxc_o);

  assert_switch_both_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_rec != $past(sel_rec)) |-> (!$past(rec_phase) && !$past(idle_src)));

  assert_lock_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_rec && !$past(sel_rec)) |-> $past(locked));

  assert_rxd_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_rec |-> !rxd_o);

  assert_rxd_on_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_rec && (rxd_o != $past(rxd_o))) |-> (rxc_o && !$past(rxc_o)));

  assert_blank_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    blanking |-> !crs_o);
endmodule

bind rxcs_seq rxcs_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_b(mode_b), .rec_phase(rec_phase),
  .idle_src(idle_src), .sel_rec(sel_rec), .locked(locked),
  .blanking(blanking), .rxc_o(rxc_o), .rxd_o(rxd_o), .crs_o(crs_o)
);

// File: tb/sim_rxcs_seq.sv
`timescale 1ns/1ps
module sim_rxcs_seq;
  localparam int LOCK  = (1500 * 20 + 999) / 1000;
  localparam int BLANK = (4400 * 20 + 999) / 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_b = 1'b0, rx_act = 1'b0, col_act = 1'b0;
  logic rec_phase = 1'b0, rec_bit = 1'b0, tx_phase = 1'b0, tx_act = 1'b0;
  logic rxc_o, rxd_o, crs_o;

  int checks = 0;
  int fails  = 0;
  int ph = 0;
  int rec_off = 0;
  logic [7:0] lfsr = 8'hA5;
  logic d_tx, d_rec, d_bit;
  logic prev_rxc, prev_rxd;

  always #4 clk = ~clk;

  rxcs_seq u0 (
    .clk(clk), .rst_n(rst_n), .mode_b(mode_b), .rx_act(rx_act),
    .col_act(col_act), .rec_phase(rec_phase), .rec_bit(rec_bit),
    .tx_phase(tx_phase), .tx_act(tx_act),
    .rxc_o(rxc_o), .rxd_o(rxd_o), .crs_o(crs_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    ph++;
    tx_phase  = ph[0];
    rec_phase = ((ph + rec_off) >> 1) & 1;
    lfsr      = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    rec_bit   = lfsr[0];
    d_tx = tx_phase; d_rec = rec_phase; d_bit = rec_bit;
    prev_rxc = rxc_o; prev_rxd = rxd_o;
    @(posedge clk);
    #2;
  endtask

  initial begin
    #(8 * 200000);
    chk("R1 watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1 reset state
    rx_act = 1'b1; col_act = 1'b1;
    for (int i = 0; i < 4; i++) tick();
    chk("R1 rxc in reset", rxc_o, 0);
    chk("R1 rxd in reset", rxd_o, 0);
    chk("R1 crs in reset", crs_o, 0);
    rx_act = 1'b0; col_act = 1'b0;
    @(negedge clk); rst_n = 1'b1;

    for (int m = 0; m < 2; m++) begin
      for (int off = 0; off < 4; off++) begin
        mode_b = m[0]; rec_off = off; rx_act = 1'b0;
        for (int i = 0; i < 8; i++) tick();
        chk(m ? "R3 idle low" : "R2 idle copies tx", rxc_o, m ? 0 : d_tx);
        rx_act = 1'b1;
        for (int n = 1; n <= 60; n++) begin
          tick();
          if (n <= LOCK) begin
            if (m) chk("R3 held low in lock", rxc_o, 0);
            else   chk("R2 copies tx in lock", rxc_o, d_tx);
            chk("R6 rxd zero in lock", rxd_o, 0);
          end
          if (n >= LOCK + 4) begin
            chk("R4 follows recovered", rxc_o, d_rec);
            if (rxc_o && !prev_rxc) chk("R7 rxd launched on rise", rxd_o, d_bit);
            else                    chk("R7 rxd stable off rise", rxd_o, prev_rxd);
          end
          chk("R5 carrier follows rx", crs_o, 1);
        end
        rx_act = 1'b0;
        for (int n = 1; n <= 8; n++) begin
          tick();
          if (n >= 4) begin
            chk("R8 back to idle source", rxc_o, m ? 0 : d_tx);
            chk("R8 rxd zero", rxd_o, 0);
          end
        end
        chk("R5 carrier drops", crs_o, 0);
      end
    end

    // R5 collision only, no blanking
    mode_b = 1'b0; col_act = 1'b1; tick();
    chk("R5 collision raises carrier", crs_o, 1);
    col_act = 1'b0; tick();
    chk("R5 carrier clears", crs_o, 0);

    // R9 blanking sweep: s is the cycle reception starts (0 = already on)
    for (int kind = 0; kind < 9; kind++) begin
      automatic int starts[9] = '{0, 0, 10, 50, 85, 88, 89, 92, 200};
      automatic int s = starts[kind];
      automatic bit colonly = (kind == 1);
      rx_act = (s == 0) && !colonly; col_act = colonly;
      tx_act = 1'b1;
      for (int i = 0; i < 5; i++) tick();
      chk("R5 carrier during transmit", crs_o, (s == 0) ? 1 : 0);
      tx_act = 1'b0;
      for (int k = 1; k <= 100; k++) begin
        if (s != 0 && k == s) rx_act = 1'b1;
        tick();
        chk("R9 blanking window", crs_o,
            ((k > BLANK) && (rx_act || col_act)) ? 1 : 0);
        if (s != 0 && k >= s && (k - s + 1) >= LOCK + 4)
          chk("R9 lock runs while blanked", rxc_o, d_rec);
      end
      rx_act = 1'b0; col_act = 1'b0;
      for (int i = 0; i < 8; i++) tick();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule